// File: doc/BRIEF.md
# Reversible-Gate Crosswise 4x4 Multiplier

This block multiplies two 4-bit unsigned operands and returns the full 8-bit product with no clock and no state. The arithmetic follows the vertical-and-crosswise scheme. Each operand is split into a low and a high 2-bit half, and four 2x2 crosswise cells form the partial products. Ripple-carry adders then combine those products at their proper weights.

Every piece of logic is an instance of a modelled reversible gate: a 2-in/2-out copy gate, a 3-in/3-out AND/XOR gate and a 4-in/4-out full-adder gate. Each of these maps its input vectors one-to-one onto its output vectors. Constant inputs are tied off, and outputs that carry no useful value are left as garbage. A signal that more than one gate needs is duplicated through a copy gate whose target is tied to 0, so no net drives two gate inputs.

In each adder, the first bit position has no carry-in. That position therefore uses the cheaper 3-in/3-out gate as a half adder, and every later position uses the 4-in/4-out full-adder gate.

Top module: `rev_vedic_mul4`

## Requirements
- R1: For every one of the 256 operand pairs, `prod_o` equals `a_i * b_i` as an unsigned 8-bit value.
- R2: `prod_o[1:0]` equals the low two bits of `a_i[1:0] * b_i[1:0]`; the product of the two low halves alone sets them.
- R3: The 2x2 crosswise cell returns the 4-bit unsigned product of its 2-bit operands for all 16 input pairs. Its bit 0 is a0·b0, and its bit 1 is the XOR of the cross terms a0·b1 and a1·b0.
- R4: The N-bit ripple adder returns the (N+1)-bit sum of its operands, with the carry-out as the top bit. Its bit-0 stage is a half adder, so it takes no carry-in.
- R5: The copy gate outputs (A, A^B). With B tied to 0, both outputs equal A.
- R6: The 3-input gate outputs (A, A^B, (A&B)^C). With C tied to 0, the third output is A AND B and the second is A XOR B.
- R7: The 4-input gate outputs (A, B, A^B^C, ((A^B)&C)^(A&B)^D). With D tied to 0, the third output is the full-adder sum and the fourth is the carry.
- R8: Each gate is a bijection: no two distinct input vectors give the same output vector.
- R9: The extreme operands give the expected products: 0 with any operand is 0, 15×15 is 225, and 1×b is b.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 4 | Unsigned multiplicand |
| b_i | input | 4 | Unsigned multiplier |
| prod_o | output | 8 | Unsigned product a_i × b_i |

## Verification
The hardest property to reach from the top ports is the bijectivity of each gate. At the top, every gate sits behind constant-0 inputs, so it only ever sees half or fewer of its input vectors. The bench therefore drives each gate type on its own through all 4, 8 or 16 input vectors and checks the outputs for collisions. It also drives the 2x2 cell and a 4-bit adder directly and exhaustively. It then sweeps all 256 operand pairs at the top, together with the zero, one and all-ones corners.

// File: rtl/rev_mul_pkg.sv
package rev_mul_pkg;
   localparam int unsigned OPND_W  = 4;
   localparam int unsigned HALF_W  = OPND_W / 2;
   localparam int unsigned PROD_W  = 2 * OPND_W;
   localparam int unsigned CELL_W  = 2 * HALF_W;
endpackage

// File: rtl/rev_feynman.sv
module rev_feynman (
   input  logic a_i,
   input  logic b_i,
   output logic p_o,
   output logic q_o
);
   assign p_o = a_i;
   assign q_o = a_i ^ b_i;
endmodule

// File: rtl/rev_peres.sv
module rev_peres (
   input  logic a_i,
   input  logic b_i,
   input  logic c_i,
   output logic p_o,
   output logic q_o,
   output logic r_o
);
   assign p_o = a_i;
   assign q_o = a_i ^ b_i;
   assign r_o = (a_i & b_i) ^ c_i;
endmodule

// File: rtl/rev_hng.sv
module rev_hng (
   input  logic a_i,
   input  logic b_i,
   input  logic c_i,
   input  logic d_i,
   output logic p_o,
   output logic q_o,
   output logic r_o,
   output logic s_o
);
   logic ab_x;
   assign ab_x = a_i ^ b_i;
   assign p_o  = a_i;
   assign q_o  = b_i;
   assign r_o  = ab_x ^ c_i;
   assign s_o  = (ab_x & c_i) ^ (a_i & b_i) ^ d_i;
endmodule

// File: rtl/rev_ripple_add.sv
module rev_ripple_add #(
   parameter int unsigned N = 4
) (
   input  logic [N-1:0] x_i,
   input  logic [N-1:0] y_i,
   output logic [N:0]   sum_o
);
   localparam int unsigned CW = N + 1;

   logic [CW-1:0] carry;
   logic [N-1:0]  gx;
   logic [N-1:0]  gy;
   logic          unused_garbage;

   assign carry[0] = 1'b0;

   if (N < 1) begin : g_bad_width
      $error("rev_ripple_add: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_stage
      if (i == 0) begin : g_half
         rev_peres u_ha (
            .a_i (x_i[i]),
            .b_i (y_i[i]),
            .c_i (1'b0),
            .p_o (gx[i]),
            .q_o (sum_o[i]),
            .r_o (carry[i+1])
         );
         assign gy[i] = 1'b0;
      end else begin : g_full
         rev_hng u_fa (
            .a_i (x_i[i]),
            .b_i (y_i[i]),
            .c_i (carry[i]),
            .d_i (1'b0),
            .p_o (gx[i]),
            .q_o (gy[i]),
            .r_o (sum_o[i]),
            .s_o (carry[i+1])
         );
      end
   end

   assign sum_o[N]       = carry[N];
   assign unused_garbage = ^{gx, gy, carry[0]};

   // R4: the gate chain yields the arithmetic sum with carry-out on top
   always_comb begin
      a_r4_ripple_sum : assert (sum_o == ({1'b0, x_i} + {1'b0, y_i}));
   end
endmodule

// File: rtl/rev_ut_cell2.sv
module rev_ut_cell2 (
   input  logic [1:0] a_i,
   input  logic [1:0] b_i,
   output logic [3:0] p_o
);
   logic a0x, a0y, a1x, a1y, b0x, b0y, b1x, b1y;
   logic t00, t01, t10, t11, c1;
   logic [3:0] gxor;
   logic [5:0] gpass;
   logic       unused_garbage;

   // copies: each operand bit is needed by two AND gates
   rev_feynman u_ca0 (.a_i(a_i[0]), .b_i(1'b0), .p_o(a0x), .q_o(a0y));
   rev_feynman u_ca1 (.a_i(a_i[1]), .b_i(1'b0), .p_o(a1x), .q_o(a1y));
   rev_feynman u_cb0 (.a_i(b_i[0]), .b_i(1'b0), .p_o(b0x), .q_o(b0y));
   rev_feynman u_cb1 (.a_i(b_i[1]), .b_i(1'b0), .p_o(b1x), .q_o(b1y));

   // vertical and crosswise bit products
   rev_peres u_m00 (.a_i(a0x), .b_i(b0x), .c_i(1'b0), .p_o(gpass[0]), .q_o(gxor[0]), .r_o(t00));
   rev_peres u_m01 (.a_i(a0y), .b_i(b1x), .c_i(1'b0), .p_o(gpass[1]), .q_o(gxor[1]), .r_o(t01));
   rev_peres u_m10 (.a_i(a1x), .b_i(b0y), .c_i(1'b0), .p_o(gpass[2]), .q_o(gxor[2]), .r_o(t10));
   rev_peres u_m11 (.a_i(a1y), .b_i(b1y), .c_i(1'b0), .p_o(gpass[3]), .q_o(gxor[3]), .r_o(t11));

   // column 1: cross terms; column 2: high term plus carry
   rev_peres u_h1 (.a_i(t01), .b_i(t10), .c_i(1'b0), .p_o(gpass[4]), .q_o(p_o[1]), .r_o(c1));
   rev_peres u_h2 (.a_i(t11), .b_i(c1),  .c_i(1'b0), .p_o(gpass[5]), .q_o(p_o[2]), .r_o(p_o[3]));

   assign p_o[0]         = t00;
   assign unused_garbage = ^{gxor, gpass};

   // R3: cell output is the 2x2 unsigned product
   always_comb begin
      a_r3_cell_product : assert (p_o == ({2'b00, a_i} * {2'b00, b_i}));
   end
endmodule

// File: rtl/rev_vedic_mul4.sv
module rev_vedic_mul4
   import rev_mul_pkg::*;
(
   input  logic [3:0] a_i,
   input  logic [3:0] b_i,
   output logic [7:0] prod_o
);
   localparam int unsigned MID_W = CELL_W;
   localparam int unsigned FIN_W = PROD_W - HALF_W;

   logic [OPND_W-1:0] ax, ay, bx, by;
   logic [CELL_W-1:0] q_ll, q_hl, q_lh, q_hh;
   logic [MID_W:0]    s_mid;
   logic [MID_W:0]    s_high;
   logic [FIN_W:0]    s_fin;
   logic              unused_garbage;

   if (OPND_W != 4) begin : g_bad_opnd
      $error("rev_vedic_mul4: operand width must be 4");
   end

   // each operand bit feeds two crosswise cells: copy it once
   for (genvar i = 0; i < OPND_W; i++) begin : g_copy
      rev_feynman u_cpa (.a_i(a_i[i]), .b_i(1'b0), .p_o(ax[i]), .q_o(ay[i]));
      rev_feynman u_cpb (.a_i(b_i[i]), .b_i(1'b0), .p_o(bx[i]), .q_o(by[i]));
   end

   rev_ut_cell2 u_ll (.a_i(ax[1:0]), .b_i(bx[1:0]), .p_o(q_ll));
   rev_ut_cell2 u_hl (.a_i(ax[3:2]), .b_i(by[1:0]), .p_o(q_hl));
   rev_ut_cell2 u_lh (.a_i(ay[1:0]), .b_i(bx[3:2]), .p_o(q_lh));
   rev_ut_cell2 u_hh (.a_i(ay[3:2]), .b_i(by[3:2]), .p_o(q_hh));

   // weight-4 column: carry-over of the low cell plus one cross term
   rev_ripple_add #(.N(MID_W)) u_add_mid (
      .x_i   ({2'b00, q_ll[3:2]}),
      .y_i   (q_hl),
      .sum_o (s_mid)
   );

   // weight-16 column: high cell plus upper half of the other cross term
   rev_ripple_add #(.N(MID_W)) u_add_high (
      .x_i   (q_hh),
      .y_i   ({2'b00, q_lh[3:2]}),
      .sum_o (s_high)
   );

   // final merge at weight 4
   rev_ripple_add #(.N(FIN_W)) u_add_fin (
      .x_i   ({1'b0, s_mid}),
      .y_i   ({s_high[3:0], q_lh[1:0]}),
      .sum_o (s_fin)
   );

   assign prod_o         = {s_fin[5:0], q_ll[1:0]};
   assign unused_garbage = ^{s_fin[FIN_W], s_high[MID_W]};

   // R1: full product
   always_comb begin
      a_r1_full_product : assert (prod_o == ({4'b0, a_i} * {4'b0, b_i}));
   end

   // R2: lowest two bits set by the low halves only
   always_comb begin
      a_r2_low_bits : assert (prod_o[1:0] == 2'(a_i[1:0] * b_i[1:0]));
   end

   // R1: no value is ever lost in the top carry positions
   always_comb begin
      a_r1_no_overflow : assert (!s_fin[FIN_W] && !s_high[MID_W]);
   end
endmodule

// File: tb/test_rev_vedic_mul4.sv
module test_rev_vedic_mul4;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   // top
   logic [3:0] a, b;
   logic [7:0] prod;
   rev_vedic_mul4 i_rev_vedic_mul4 (.a_i(a), .b_i(b), .prod_o(prod));

   // stand-alone gates and sub-blocks
   logic fa, fb, fp, fq;
   rev_feynman u_fey (.a_i(fa), .b_i(fb), .p_o(fp), .q_o(fq));
   logic pa, pb, pc, pp, pq, pr;
   rev_peres u_per (.a_i(pa), .b_i(pb), .c_i(pc), .p_o(pp), .q_o(pq), .r_o(pr));
   logic ha, hb, hc, hd, hp, hq, hr, hs;
   rev_hng u_hng (.a_i(ha), .b_i(hb), .c_i(hc), .d_i(hd),
                  .p_o(hp), .q_o(hq), .r_o(hr), .s_o(hs));
   logic [1:0] ca, cb;
   logic [3:0] cp;
   rev_ut_cell2 u_cell (.a_i(ca), .b_i(cb), .p_o(cp));
   logic [3:0] rx, ry;
   logic [4:0] rs;
   rev_ripple_add #(.N(4)) u_add (.x_i(rx), .y_i(ry), .sum_o(rs));

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic settle();
      @(negedge clk);
      #2;
   endtask

   task automatic t_reset_state();
      a = 4'd0; b = 4'd0;
      settle();
      check("R9 initial zero", int'(prod), 0);
   endtask

   task automatic t_feynman();
      logic [3:0] seen = '0;
      for (int v = 0; v < 4; v++) begin
         {fa, fb} = 2'(v);
         settle();
         check("R5 feynman", int'({fp, fq}), int'({fa, fa ^ fb}));
         if (!fb) check("R5 copy", int'(fq), int'(fa));
         check("R8 feynman unique", int'(seen[{fp, fq}]), 0);
         seen[{fp, fq}] = 1'b1;
      end
   endtask

   task automatic t_peres();
      logic [7:0] seen = '0;
      for (int v = 0; v < 8; v++) begin
         {pa, pb, pc} = 3'(v);
         settle();
         check("R6 peres", int'({pp, pq, pr}), int'({pa, pa ^ pb, (pa & pb) ^ pc}));
         check("R8 peres unique", int'(seen[{pp, pq, pr}]), 0);
         seen[{pp, pq, pr}] = 1'b1;
      end
   endtask

   task automatic t_hng();
      logic [15:0] seen = '0;
      for (int v = 0; v < 16; v++) begin
         {ha, hb, hc, hd} = 4'(v);
         settle();
         check("R7 hng", int'({hp, hq, hr, hs}),
               int'({ha, hb, ha ^ hb ^ hc, ((ha ^ hb) & hc) ^ (ha & hb) ^ hd}));
         if (!hd) check("R7 full add", int'({hs, hr}), int'(ha) + int'(hb) + int'(hc));
         check("R8 hng unique", int'(seen[{hp, hq, hr, hs}]), 0);
         seen[{hp, hq, hr, hs}] = 1'b1;
      end
   endtask

   task automatic t_cell();
      for (int v = 0; v < 16; v++) begin
         {ca, cb} = 4'(v);
         settle();
         check("R3 cell", int'(cp), int'(ca) * int'(cb));
      end
   endtask

   task automatic t_adder();
      for (int v = 0; v < 256; v++) begin
         {rx, ry} = 8'(v);
         settle();
         check("R4 ripple", int'(rs), int'(rx) + int'(ry));
      end
   endtask

   task automatic t_full_sweep();
      for (int v = 0; v < 256; v++) begin
         {a, b} = 8'(v);
         settle();
         check("R1 product", int'(prod), int'(a) * int'(b));
         check("R2 low bits", int'(prod[1:0]), (int'(a[1:0]) * int'(b[1:0])) % 4);
      end
   endtask

   task automatic t_corners();
      a = 4'd15; b = 4'd15; settle();
      check("R9 max", int'(prod), 225);
      for (int v = 0; v < 16; v++) begin
         a = 4'd0; b = 4'(v); settle();
         check("R9 zero", int'(prod), 0);
         a = 4'd1; settle();
         check("R9 one", int'(prod), v);
      end
   endtask

   initial begin
      a = '0; b = '0; fa = 0; fb = 0; pa = 0; pb = 0; pc = 0;
      ha = 0; hb = 0; hc = 0; hd = 0; ca = '0; cb = '0; rx = '0; ry = '0;
      t_reset_state();
      t_feynman();
      t_peres();
      t_hng();
      t_cell();
      t_adder();
      t_full_sweep();
      t_corners();
      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule